// File: doc/BRIEF.md
# Four-Stage Instruction Pipeline Sequencer

This block steers 12-bit instruction words through a four-deep overlap of fetch, decode, execute and write-back. It owns the 11-bit program counter, presents the fetch address to an external program store, captures the word that comes back, and hands the word now in execute to the datapath. Each instruction cycle moves every stage one step forward. Once the pipe has filled, one instruction completes per instruction cycle.

The datapath reports two events while an instruction sits in execute. The first is a control transfer (jump or call), which comes with a target address. The second is a conditional skip whose condition came out true. On either event the sequencer raises a flush. It then discards the younger work and refills from the right address, so the event costs one empty execute slot. A speed-select input sets the instruction cycle to every clock or to every fourth clock.

Top module: `insn_pipe_seq`

## Requirements
- R1: While reset is asserted (sampled at a clock edge), all four stage-valid flags, the fetch address, flush and the retire strobe read zero.
- R2: With `turbo_i` high, every clock edge is an advance. With it low, only every fourth clock edge is an advance, and the first is the fourth edge after reset is released. Between advances the stage flags and the fetch address hold.
- R3: Stage flags are bit 0 fetch, bit 1 decode, bit 2 execute and bit 3 write-back. After reset they fill as 0001, 0011, 0111, 1111 on the first four advances. The retire strobe is first high in the clock after the fourth advance: clock 4 after release in turbo mode, clock 16 in slow mode.
- R4: On advances without a transfer, once the fetch flag is set, the fetch address rises by one. It wraps from 2047 to 0.
- R5: At an advance the word on `fetch_word_i` enters decode. At the next advance it moves to execute and appears on `exe_word_o`.
- R6: A transfer is taken when `xfer_i` is high in an advance cycle with the execute flag set. In that same cycle `flush_o` is high and `fetch_addr_o` equals `xfer_target_i`, so the target word enters decode. After the edge the execute flag is clear, and the fetch address that follows is target+1.
- R7: A skip is taken when `skip_i` is high in an advance cycle with the execute flag set and no transfer. `flush_o` is high, the instruction in decode is discarded (execute flag clear after the edge), and fetch continues from the current fetch address, which is the address just past the skipped word.
- R8: When `xfer_i` and `skip_i` are both high, the transfer wins and the fetch address is the target.
- R9: `xfer_i` and `skip_i` have no effect in a non-advance cycle, or while the execute flag is clear. `flush_o` stays low and the fetch sequence is unchanged.
- R10: The instruction in execute that causes a flush still moves to write-back and produces a retire strobe in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| turbo_i | input | 1 | 1: advance every clock; 0: advance every fourth clock |
| fetch_word_i | input | 12 | Word read from program store at `fetch_addr_o` |
| xfer_i | input | 1 | Execute-stage instruction is a jump or call |
| xfer_target_i | input | 11 | Destination of the transfer |
| skip_i | input | 1 | Execute-stage skip condition is true |
| vld_o | output | 4 | Stage-valid flags (fetch, decode, execute, write-back = bits 0..3) |
| fetch_addr_o | output | 11 | Program store address |
| exe_word_o | output | 12 | Instruction word in execute |
| flush_o | output | 1 | Younger stages discarded in this advance |
| retire_o | output | 1 | One-clock pulse per instruction entering write-back |

## Verification
A transfer and a skip can be requested in the same advance cycle. The bench raises both together often, from a pseudo-random source, in both speed modes. It judges the result by whether the fetch address in that cycle is the transfer target and whether exactly one execute slot is lost. Flush requests are also held across the non-advance clocks of the slow mode and raised during the refill bubble, where they must be ignored. A cycle-by-cycle address-tracking model in the bench gives the expected flags, address, flush, retire and execute word.

// File: rtl/ips_pkg.sv
// Shared constants for the instruction pipeline sequencer.
// Assumes exactly four stages, indexed in pipeline order.
package ips_pkg;
    localparam int unsigned NUM_STG = 4;
    localparam int unsigned STG_FE  = 0;
    localparam int unsigned STG_DE  = 1;
    localparam int unsigned STG_EX  = 2;
    localparam int unsigned STG_WB  = 3;
endpackage

// File: rtl/ips_rate_div.sv
// Instruction-cycle enable generator.
// Produces adv_o on every clock in turbo mode, otherwise once per
// SLOW_DIV clocks. The phase counter runs freely from reset, so a mode
// change takes effect at once without resynchronising.
module ips_rate_div #(
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic turbo_i,
    output logic adv_o
);
    localparam int unsigned CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] phase_q;

    // Free-running phase counter, wraps after SLOW_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    // Advance strobe: every clock in turbo mode, else on the last phase.
    always_comb adv_o = turbo_i | (phase_q == LAST);

    // R2: in slow mode two advances are never back to back
    a_r2_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!turbo_i && adv_o) |=> (turbo_i || !adv_o));
endmodule

// File: rtl/ips_fetch_ctl.sv
// Program counter and fetch address selection.
// Assumes a combinational-read program store: on a taken transfer the
// target is presented in the same cycle so its word enters decode at once.
module ips_fetch_ctl #(
    parameter int unsigned PC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            fe_live_i,
    input  logic            redirect_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] fetch_addr_o
);
    logic [PC_W-1:0] pc_q;

    // Fetch address: redirect target overrides the running counter.
    always_comb fetch_addr_o = redirect_i ? target_i : pc_q;

    // Counter update: past the target on redirect, else step once fetch is live.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pc_q <= '0;
        else if (adv_i && redirect_i) pc_q <= target_i + 1'b1;
        else if (adv_i && fe_live_i)  pc_q <= pc_q + 1'b1;
    end

    // R2: counter holds between advances
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(pc_q));
    // R6: after a taken transfer the counter sits one past the target
    a_r6_pc_target: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && redirect_i) |=> (pc_q == $past(target_i) + 1'b1));
    // R4: sequential step of exactly one (modulo wrap)
    a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !redirect_i && fe_live_i) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/ips_stage_track.sv
// Stage-valid flags, in-flight instruction words and retire strobe.
// Assumes kill_i is only raised in an advance with the execute flag set;
// it discards the word moving from decode into execute.
module ips_stage_track
    import ips_pkg::*;
#(
    parameter int unsigned IW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               kill_i,
    input  logic [IW-1:0]      fetch_word_i,
    output logic [NUM_STG-1:0] vld_o,
    output logic [IW-1:0]      exe_word_o,
    output logic               retire_o
);
    logic [NUM_STG-1:0] vld_q;
    logic [IW-1:0]      dec_word_q;
    logic [IW-1:0]      exe_word_q;
    logic               retire_q;

    // Fetch flag: live from the first advance onward.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q[STG_FE] <= 1'b0;
        else if (adv_i) vld_q[STG_FE] <= 1'b1;
    end

    // Older flags: shift one stage per advance; kill clears the entry into execute.
    for (genvar s = 1; s < NUM_STG; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)     vld_q[s] <= 1'b0;
            else if (adv_i) vld_q[s] <= vld_q[s-1] & ~((s == STG_EX) && kill_i);
        end
    end

    // Word registers: capture the fetched word, then move it into execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_word_q <= '0;
            exe_word_q <= '0;
        end else if (adv_i) begin
            dec_word_q <= fetch_word_i;
            exe_word_q <= dec_word_q;
        end
    end

    // Retire pulse: one clock after an instruction enters write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) retire_q <= 1'b0;
        else        retire_q <= adv_i & vld_q[STG_EX];
    end

    always_comb begin
        vld_o      = vld_q;
        exe_word_o = exe_word_q;
        retire_o   = retire_q;
    end

    // R3: flags stay contiguous from fetch
    a_r3_exec_needs_dec: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[STG_EX] |-> vld_q[STG_DE]);
    a_r3_dec_needs_fe: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[STG_DE] |-> vld_q[STG_FE]);
    // R3: a retire always has a write-back entry behind it
    a_r3_retire_wb: assert property (@(posedge clk) disable iff (!rst_n)
        retire_q |-> vld_q[STG_WB]);
    // R7: a kill leaves execute empty
    a_r7_kill_empties_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && kill_i) |=> !vld_q[STG_EX]);
endmodule

// File: rtl/insn_pipe_seq.sv
// Four-stage instruction pipeline sequencer (top).
// Takes jump/skip outcomes from the execute stage, decides flush and
// redirect, and ties together the rate divider, fetch control and stage
// tracking. A transfer outranks a skip when both are reported.
module insn_pipe_seq
    import ips_pkg::*;
#(
    parameter int unsigned PC_W     = 11,
    parameter int unsigned IW       = 12,
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               turbo_i,
    input  logic [IW-1:0]      fetch_word_i,
    input  logic               xfer_i,
    input  logic [PC_W-1:0]    xfer_target_i,
    input  logic               skip_i,
    output logic [NUM_STG-1:0] vld_o,
    output logic [PC_W-1:0]    fetch_addr_o,
    output logic [IW-1:0]      exe_word_o,
    output logic               flush_o,
    output logic               retire_o
);
    logic adv;
    logic ex_live;
    logic take_xfer;
    logic take_skip;

    ips_rate_div #(.SLOW_DIV(SLOW_DIV)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .turbo_i (turbo_i),
        .adv_o   (adv)
    );

    // Event qualification: only an advance with a live execute entry counts.
    always_comb begin
        ex_live   = adv & vld_o[STG_EX];
        take_xfer = ex_live & xfer_i;
        take_skip = ex_live & skip_i & ~xfer_i;
        flush_o   = take_xfer | take_skip;
    end

    ips_fetch_ctl #(.PC_W(PC_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (adv),
        .fe_live_i    (vld_o[STG_FE]),
        .redirect_i   (take_xfer),
        .target_i     (xfer_target_i),
        .fetch_addr_o (fetch_addr_o)
    );

    ips_stage_track #(.IW(IW)) u_stages (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (adv),
        .kill_i       (flush_o),
        .fetch_word_i (fetch_word_i),
        .vld_o        (vld_o),
        .exe_word_o   (exe_word_o),
        .retire_o     (retire_o)
    );

    // R10: the flushing instruction itself retires
    a_r10_flush_retires: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> retire_o);
    // R9: no flush while execute is empty
    a_r9_no_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o[STG_EX] |-> !flush_o);
    // R6: a redirected fetch leaves a live decode entry
    a_r6_refill_decode: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> vld_o[STG_DE]);
endmodule

// File: tb/insn_pipe_seq_tb.sv
`timescale 1ns/1ps
module insn_pipe_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        turbo = 1'b1;
    logic        xfer = 1'b0;
    logic        skip = 1'b0;
    logic [10:0] tgt = '0;
    logic [11:0] fword;
    logic [3:0]  vld;
    logic [10:0] faddr;
    logic [11:0] eword;
    logic        flush, retire;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [11:0] memw(input logic [10:0] a);
        return 12'(a * 29 + 11);
    endfunction

    assign fword = memw(faddr);

    insn_pipe_seq u_dut (
        .clk(clk), .rst_n(rst_n), .turbo_i(turbo), .fetch_word_i(fword),
        .xfer_i(xfer), .xfer_target_i(tgt), .skip_i(skip),
        .vld_o(vld), .fetch_addr_o(faddr), .exe_word_o(eword),
        .flush_o(flush), .retire_o(retire)
    );

    // Address-tracking reference model.
    logic [1:0]  m_cnt;
    logic [3:0]  m_v;
    logic [10:0] m_pc, m_dadr, m_eadr;
    logic        m_ret;

    function automatic bit m_adv();
        return turbo || (m_cnt == 2'd3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_v <= 0; m_pc <= 0; m_dadr <= 0; m_eadr <= 0; m_ret <= 0;
        end else begin
            m_cnt <= m_cnt + 2'd1;
            if (m_adv()) begin
                automatic bit tx = m_v[2] && xfer;
                automatic bit ts = m_v[2] && skip && !xfer;
                automatic logic [10:0] fa = tx ? tgt : m_pc;
                m_v    <= {m_v[2], m_v[1] && !(tx || ts), m_v[0], 1'b1};
                m_ret  <= m_v[2];
                m_eadr <= m_dadr;
                m_dadr <= fa;
                m_pc   <= tx ? 11'(tgt + 11'd1) : (m_v[0] ? 11'(m_pc + 11'd1) : m_pc);
            end else begin
                m_ret <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        automatic bit a  = m_adv();
        automatic bit tx = a && m_v[2] && xfer;
        automatic bit ts = a && m_v[2] && skip && !xfer;
        automatic string fr = (tx && skip) ? "R8" : tx ? "R6" : ts ? "R7" :
                              (xfer || skip) ? "R9" : "R6";
        chk(turbo ? "R3 stage flags" : "R2 stage flags", 32'(vld), 32'(m_v));
        chk((tx && skip) ? "R8 fetch address" : "R4 fetch address",
            32'(faddr), 32'(tx ? tgt : m_pc));
        chk(fr, 32'(flush), 32'(tx || ts));
        chk("R10 retire", 32'(retire), 32'(m_ret));
        if (m_v[2]) chk("R5 execute word", 32'(eword), 32'(memw(m_eadr)));
    endtask

    logic [15:0] lf = 16'hACE1;

    task automatic run_phase(input bit tmode, input int ncyc, input int wrap_at, input int hold);
        automatic bit seen = 0;
        @(negedge clk);
        rst_n = 1'b0; turbo = tmode; xfer = 0; skip = 0; tgt = 0;
        repeat (2) @(negedge clk);
        chk("R1 flags", 32'(vld), 0);
        chk("R1 fetch address", 32'(faddr), 0);
        chk("R1 flush", 32'(flush), 0);
        chk("R1 retire", 32'(retire), 0);
        rst_n = 1'b1;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (retire && !seen) begin
                seen = 1;
                chk("R3 first retire clock", 32'(c), tmode ? 32'd4 : 32'd16);
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (c >= wrap_at && c < wrap_at + hold) begin
                xfer = 1; skip = 0; tgt = 11'd2044;
            end else if (c >= wrap_at + hold && c < wrap_at + 25 * hold) begin
                xfer = 0; skip = 0;
            end else begin
                xfer = (lf[2:0] == 3'd0) || (lf[7:5] == 3'd2);
                skip = (lf[4:3] == 2'd1);
                tgt  = (lf[9:8] == 2'd3) ? 11'(2040 + lf[14:12]) : lf[15:5];
            end
            #1;
            compare_all();
        end
        xfer = 0; skip = 0;
    endtask

    initial begin
        run_phase(1'b1, 600, 300, 1);
        run_phase(1'b0, 2000, 1000, 4);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule